// File: doc/BRIEF.md
# Static Memory Write Strobe Sequencer

This block runs one write cycle to an asynchronous static memory bank. It runs on the CPU clock. All its edges fall on CPU-clock boundaries, and each CPU tick is half of a memory clock period. A request carries an address, a data word, a bank index, a 2-bit memory type code and two 5-bit strobe-length fields. The block accepts a request only while it is idle. It latches the request and then plays out a fixed sequence on the memory pins: address, chip select, write enable and the data drive window. It ends with a one-cycle done pulse.

Setup and hold spacings around the write strobe are fixed. The strobe width comes from one of the two length fields, and the type code picks which one. When idle, chip selects and write enable rest high and the data bus is released.

Top module: `smem_write_seq`

## Requirements
- R1: During and after reset, and whenever no write is running, every `mem_cs_n` bit and `mem_we_n` are 1, `mem_data_oe` and `done` are 0, and `ready` is 1.
- R2: A request is taken only on a clock edge where `req_valid` is 1 and `ready` is 1. A request presented while `ready` is 0 has no effect on the running write or on the pins.
- R3: Counting the first cycle after acceptance as tick 0, `mem_addr` carries the accepted address from tick 0 through the last tick of the write and does not change in between.
- R4: Only the chip select whose bit index equals `req_bank` goes low, from tick 1. At most one chip select bit is low at any time.
- R5: `mem_we_n` goes low at tick 5, four ticks after chip select asserts.
- R6: `mem_we_n` stays low for 3 + 2*N ticks. N is `req_rdn` when `req_mtype` is 2'b00 or 2'b01, and `req_rdf` when `req_mtype[1]` is 1. Write enable therefore rises at tick W = 8 + 2*N.
- R7: `mem_data_oe` is 1, with `mem_data` equal to the accepted data, from tick 5 through tick W+2. This gives three ticks of data hold after write enable rises.
- R8: Chip select returns high at tick W+2, two ticks after write enable rises.
- R9: `done` is 1 for exactly tick W+2. `ready` is 0 from tick 0 through tick W+2 and is 1 again at tick W+3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | CPU clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Write request present |
| req_addr | input | AW | Write address |
| req_data | input | DW | Write data |
| req_bank | input | BW | Bank index selecting the chip select |
| req_mtype | input | 2 | Memory type code choosing the strobe-length field |
| req_rdn | input | DLYW | Strobe length field used for types 00 and 01 |
| req_rdf | input | DLYW | Strobe length field used for types 1x |
| ready | output | 1 | Idle, a request may be accepted |
| done | output | 1 | One-cycle pulse in the last tick of a write |
| mem_addr | output | AW | Memory address bus |
| mem_cs_n | output | NBANK | Active-low chip selects, one per bank |
| mem_we_n | output | 1 | Active-low write enable |
| mem_data | output | DW | Write data bus value |
| mem_data_oe | output | 1 | Data bus drive enable |

## Verification
The completion of one write can coincide with a new request. A request held high across the done tick must not be taken in that tick; it must start one tick later, in the first idle cycle. The bench provokes this by holding `req_valid` through two writes in a row. It also raises requests, with a different address, in the middle of a long strobe. A cycle-by-cycle queue model, filled from the tick rules at each acceptance, then judges whether every pin matches the schedule of the write already in flight and whether the second write starts exactly after the idle cycle.

// File: rtl/smem_wr_pkg.sv
package smem_wr_pkg;
    // Fixed spacings in CPU ticks, counted from the first cycle after acceptance
    localparam int CS_LEAD   = 1;  // chip select after address
    localparam int WE_LEAD   = 5;  // write enable low after address
    localparam int WE_BASE   = 3;  // strobe = WE_BASE + 2*N
    localparam int CS_TAIL   = 2;  // chip select held after write enable rises
    localparam int DATA_TAIL = 3;  // data and address held after write enable rises

    typedef logic [1:0] mtype_t;
endpackage

// File: rtl/smem_wr_width_sel.sv
module smem_wr_width_sel
    import smem_wr_pkg::*;
#(
    parameter int DLYW = 5,
    parameter int CW   = 7
) (
    input  mtype_t            mtype,
    input  logic [DLYW-1:0]   rdn,
    input  logic [DLYW-1:0]   rdf,
    output logic [CW-1:0]     we_end
);
    logic [DLYW-1:0] n_sel;

    always_comb begin
        n_sel  = mtype[1] ? rdf : rdn;
        we_end = CW'(WE_LEAD + WE_BASE) + (CW'(n_sel) << 1);
    end
endmodule

// File: rtl/smem_bank_dec.sv
module smem_bank_dec #(
    parameter int NBANK = 4,
    parameter int BW    = 2
) (
    input  logic             en,
    input  logic [BW-1:0]    sel,
    output logic [NBANK-1:0] cs_n
);
    for (genvar b = 0; b < NBANK; b++) begin : g_bank
        assign cs_n[b] = !(en && (sel == BW'(b)));
    end
endmodule

// File: rtl/smem_write_seq.sv
module smem_write_seq
    import smem_wr_pkg::*;
#(
    parameter int AW    = 26,
    parameter int DW    = 32,
    parameter int NBANK = 4,
    parameter int DLYW  = 5,
    parameter int BW    = (NBANK > 1) ? $clog2(NBANK) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic [AW-1:0]    req_addr,
    input  logic [DW-1:0]    req_data,
    input  logic [BW-1:0]    req_bank,
    input  logic [1:0]       req_mtype,
    input  logic [DLYW-1:0]  req_rdn,
    input  logic [DLYW-1:0]  req_rdf,
    output logic             ready,
    output logic             done,
    output logic [AW-1:0]    mem_addr,
    output logic [NBANK-1:0] mem_cs_n,
    output logic             mem_we_n,
    output logic [DW-1:0]    mem_data,
    output logic             mem_data_oe
);
    localparam int MAX_TICK = WE_LEAD + WE_BASE + 2 * ((1 << DLYW) - 1) + DATA_TAIL;
    localparam int CW       = $clog2(MAX_TICK + 1);

    typedef struct packed {
        logic          busy;
        logic [CW-1:0] tick;
        logic [CW-1:0] we_end;
        logic [AW-1:0] addr;
        logic [DW-1:0] data;
        logic [BW-1:0] bank;
        logic          cs_en;
        logic          we_n;
        logic          oe;
        logic          done;
    } st_t;

    st_t           st_d, st_q;
    logic [CW-1:0] sel_we_end;

    smem_wr_width_sel #(.DLYW(DLYW), .CW(CW)) i_width (
        .mtype  (req_mtype),
        .rdn    (req_rdn),
        .rdf    (req_rdf),
        .we_end (sel_we_end)
    );

    always_comb begin
        st_d = st_q;
        if (!st_q.busy) begin
            if (req_valid) begin
                st_d.busy   = 1'b1;
                st_d.tick   = '0;
                st_d.we_end = sel_we_end;
                st_d.addr   = req_addr;
                st_d.data   = req_data;
                st_d.bank   = req_bank;
            end
        end else if (st_q.tick == st_q.we_end + CW'(DATA_TAIL - 1)) begin
            st_d.busy = 1'b0;
        end else begin
            st_d.tick = st_q.tick + 1'b1;
        end
        // Pin levels for the coming cycle, decoded from the next tick
        st_d.cs_en = st_d.busy && (st_d.tick >= CW'(CS_LEAD))
                     && (st_d.tick < st_d.we_end + CW'(CS_TAIL));
        st_d.we_n  = !(st_d.busy && (st_d.tick >= CW'(WE_LEAD))
                       && (st_d.tick < st_d.we_end));
        st_d.oe    = st_d.busy && (st_d.tick >= CW'(WE_LEAD));
        st_d.done  = st_d.busy && (st_d.tick == st_d.we_end + CW'(DATA_TAIL - 1));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q      <= '0;
            st_q.we_n <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    smem_bank_dec #(.NBANK(NBANK), .BW(BW)) i_dec (
        .en   (st_q.cs_en),
        .sel  (st_q.bank),
        .cs_n (mem_cs_n)
    );

    assign ready       = !st_q.busy;
    assign done        = st_q.done;
    assign mem_addr    = st_q.addr;
    assign mem_data    = st_q.data;
    assign mem_we_n    = st_q.we_n;
    assign mem_data_oe = st_q.oe;

    // Assertions
    logic cs_any;
    assign cs_any = (mem_cs_n != {NBANK{1'b1}});

    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        ready |-> (!cs_any && mem_we_n && !mem_data_oe && !done));

    p_no_take_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!ready && !done) |=> !ready);

    p_addr_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!ready && $past(!ready)) |-> $stable(mem_addr));

    p_one_bank_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~mem_cs_n));

    p_cs_lead_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mem_we_n) |-> ($past(cs_any, 4) && !$past(cs_any, 5)));

    p_we_in_window_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n |-> (cs_any && mem_data_oe));

    p_cs_tail_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_we_n) |=> (cs_any && mem_data_oe));

    p_cs_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_we_n) |=> ##1 (!cs_any && mem_data_oe && done));

    p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (ready && !done));
endmodule

// File: tb/test_smem_write_seq.sv
`timescale 1ns/1ps
module test_smem_write_seq;
    localparam int AW = 26;
    localparam int DW = 32;
    localparam int NB = 4;
    localparam int DL = 5;
    localparam int BW = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_data = '0;
    logic [BW-1:0] req_bank = '0;
    logic [1:0]    req_mtype = '0;
    logic [DL-1:0] req_rdn = '0;
    logic [DL-1:0] req_rdf = '0;
    logic          ready, done, mem_we_n, mem_data_oe;
    logic [AW-1:0] mem_addr;
    logic [NB-1:0] mem_cs_n;
    logic [DW-1:0] mem_data;

    always #4 clk = ~clk;  // 125 MHz

    smem_write_seq #(.AW(AW), .DW(DW), .NBANK(NB), .DLYW(DL)) i_smem_write_seq (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
        .req_data(req_data), .req_bank(req_bank), .req_mtype(req_mtype),
        .req_rdn(req_rdn), .req_rdf(req_rdf), .ready(ready), .done(done),
        .mem_addr(mem_addr), .mem_cs_n(mem_cs_n), .mem_we_n(mem_we_n),
        .mem_data(mem_data), .mem_data_oe(mem_data_oe)
    );

    int checks = 0;
    int failures = 0;
    int cyc = 0;
    bit finished = 1'b0;

    // Expected pins per tick: {cs_n, we_n, oe, done, ready}
    logic [NB+3:0] sched[$];
    logic [AW-1:0] exp_addr;
    logic [DW-1:0] exp_data;

    task automatic chk(input bit ok, input string what, input logic [63:0] act,
                       input logic [63:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s cycle %0d actual %0h expected %0h", what, cyc, act, exp);
        end
    endtask

    // Reference model: compare at the falling edge, then queue a new write
    always @(negedge clk) begin
        logic [NB+3:0] v;
        bool_busy: begin end
        cyc++;
        if (!rst_n) begin
            sched.delete();
            v = {{NB{1'b1}}, 1'b1, 1'b0, 1'b0, 1'b1};
        end else if (sched.size() > 0) begin
            v = sched.pop_front();
        end else begin
            v = {{NB{1'b1}}, 1'b1, 1'b0, 1'b0, 1'b1};
        end
        chk(mem_cs_n == v[NB+3:4], "R1/R4/R8 cs_n", 64'(mem_cs_n), 64'(v[NB+3:4]));
        chk(mem_we_n == v[3], "R5/R6 we_n", 64'(mem_we_n), 64'(v[3]));
        chk(mem_data_oe == v[2], "R7 data_oe", 64'(mem_data_oe), 64'(v[2]));
        chk(done == v[1], "R9 done", 64'(done), 64'(v[1]));
        chk(ready == v[0], "R2/R9 ready", 64'(ready), 64'(v[0]));
        if (!v[0]) chk(mem_addr == exp_addr, "R3 addr", 64'(mem_addr), 64'(exp_addr));
        if (v[2])  chk(mem_data == exp_data, "R7 data", 64'(mem_data), 64'(exp_data));
        // R2: a new write starts only from a cycle where ready is expected high
        if (rst_n && req_valid && v[0]) begin
            int n, w;
            n = req_mtype[1] ? int'(req_rdf) : int'(req_rdn);  // R6 field choice
            w = 8 + 2 * n;
            exp_addr = req_addr;
            exp_data = req_data;
            for (int k = 0; k <= w + 2; k++) begin
                logic [NB-1:0] cs;
                cs = {NB{1'b1}};
                if (k >= 1 && k <= w + 1) cs[req_bank] = 1'b0;
                sched.push_back({cs, !(k >= 5 && k < w), (k >= 5), (k == w + 2), 1'b0});
            end
        end
    end

    task automatic set_req(input logic [BW-1:0] b, input logic [1:0] mt,
                           input int rdn, input int rdf,
                           input logic [AW-1:0] a, input logic [DW-1:0] d);
        req_bank  = b;
        req_mtype = mt;
        req_rdn   = DL'(rdn);
        req_rdf   = DL'(rdf);
        req_addr  = a;
        req_data  = d;
    endtask

    task automatic wait_ready(input logic lvl);
        forever begin
            @(negedge clk);
            if (ready == lvl) break;
        end
    endtask

    task automatic write1(input logic [BW-1:0] b, input logic [1:0] mt,
                          input int rdn, input int rdf,
                          input logic [AW-1:0] a, input logic [DW-1:0] d);
        @(posedge clk); #1;
        set_req(b, mt, rdn, rdf, a, d);
        req_valid = 1'b1;
        wait_ready(1'b1);
        @(posedge clk); #1;
        req_valid = 1'b0;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        repeat (2) @(posedge clk);
        // R6: type 00 uses rdn, minimum strobe
        write1(2'd0, 2'b00, 0, 17, 26'h0123456, 32'hDEADBEEF);
        wait_ready(1'b1);
        // R6: type 10 uses rdf, maximum strobe
        write1(2'd3, 2'b10, 4, 31, 26'h3FFFFFF, 32'h00000001);
        // R2: requests during the strobe, with other values, must be ignored
        @(posedge clk); #1;
        set_req(2'd1, 2'b00, 0, 0, 26'h1555555, 32'hCAFEF00D);
        req_valid = 1'b1;
        repeat (6) @(posedge clk);
        #1 req_valid = 1'b0;
        wait_ready(1'b1);
        // R6: type 01 behaves like 00, type 11 like 10
        write1(2'd2, 2'b01, 3, 9, 26'h2AAAAAA, 32'h5A5A5A5A);
        wait_ready(1'b1);
        write1(2'd1, 2'b11, 20, 2, 26'h0000010, 32'hFFFFFFFF);
        wait_ready(1'b1);
        // R9: request held across done starts right after the idle cycle
        @(posedge clk); #1;
        set_req(2'd3, 2'b00, 1, 0, 26'h0F0F0F0, 32'h12345678);
        req_valid = 1'b1;
        wait_ready(1'b1);
        wait_ready(1'b0);
        wait_ready(1'b1);
        @(posedge clk); #1;
        req_valid = 1'b0;
        wait_ready(1'b1);
        repeat (4) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        #(8 * 150000);
        if (!finished) begin
            finished = 1'b1;
            failures++;
            $display("FAIL watchdog cycle %0d actual hung expected finish", cyc);
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule